// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block moves a run of data elements for one DMA channel. A single descriptor word, presented together with a source base and a destination base, sets how wide each element is, how far each address advances, how many elements move, which completion flags fire and whether another descriptor follows. A started transfer copies one element at a time over a simple request/acknowledge memory port. It reads from the source address, writes the captured word to the destination address, then advances both addresses and counts down.

A descriptor starts at once when its software-start bit is set. Otherwise the engine holds it and waits for an external trigger pulse. At the end the engine pulses one or both completion flags. If chaining was requested, it stays busy and waits for the next descriptor, which starts without any trigger. An abort lets the element in flight finish and then returns the engine to rest.

The controller has five named states:

- `ST_IDLE`: at rest.
- `ST_ARMED`: holding a descriptor and waiting for the trigger.
- `ST_READ`: source read outstanding.
- `ST_WRITE`: destination write outstanding.
- `ST_LINK`: chained, waiting for the next descriptor.

Its transitions are:

- **accept**: IDLE/ARMED/LINK go to READ, or to ARMED when there is no start bit and the state is not LINK.
- **reject**: IDLE/ARMED/LINK go to IDLE when the width code is 3.
- **trigger**: ARMED goes to READ.
- **cancel**: ARMED/LINK go to IDLE on abort.
- **read-ack**: READ goes to WRITE.
- **next**: WRITE goes to READ.
- **finish**: WRITE goes to IDLE or LINK.
- **halt**: WRITE goes to IDLE after an abort.

Top module: `dma_xfer_engine`

## Requirements
- R1: The descriptor word uses this layout:
  - bit 0: valid
  - bit 1: chain
  - bit 2: software start
  - bit 3: flag A request
  - bit 4: flag B request
  - bits 6:5: width code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit)
  - bits 8:7: source step code
  - bits 10:9: destination step code
  - bits 20:11: element count minus one

  A load whose valid bit is clear is ignored, and a later trigger then has no effect.
- R2: A valid descriptor with width code 3 is rejected. `err` pulses for one cycle, no memory request is made and the engine stays at rest. `mem_size` never shows 3 during a request.
- R3: With the software-start bit set, the first read request appears in the cycle after the load. Without it, the engine is not busy and waits for a `hw_req` pulse, and the read follows in the next cycle.
- R4: Each element is handled in three steps:
  - a read at the source address;
  - a write of the captured read data to the destination address;
  - the next read, which is issued only after the write is acknowledged.

  A request holds its address and direction until `mem_ack`, and `mem_size` equals the width code.
- R5: Step code 0 leaves the address unchanged. Codes 1, 2 and 3 add 1, 2 and 4 times the element size in bytes. Source and destination follow their own codes, and both advance on each write acknowledge.
- R6: A count field of N-1 moves exactly N elements, from 1 up to 1024.
- R7: In the cycle after the last write is acknowledged, `irq_a` and `irq_b` each pulse for one cycle if their request bit was set.
- R8: `busy` is high from the first read request until the last write is acknowledged, and low after reset and while waiting for a trigger.
- R9: With the chain bit set, `busy` stays high after the last element. A following valid descriptor starts its first read in the next cycle without any trigger.
- R10: An abort during a transfer lets the current element's read and write complete, then stops with no completion flags. An abort while waiting for a trigger or a chained descriptor returns to rest.
- R11: An abort in the same cycle as the final write acknowledge still raises the requested flags, but the chain is not followed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_load | input | 1 | Present a descriptor this cycle |
| desc_word | input | 21 | Descriptor word (layout in R1) |
| src_base | input | ADDR_W | First source address |
| dst_base | input | ADDR_W | First destination address |
| hw_req | input | 1 | External start trigger |
| abort | input | 1 | Stop request |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Request address |
| mem_size | output | 2 | Element width code |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Request accepted this cycle |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` on a read |
| busy | output | 1 | Transfer in progress |
| irq_a | output | 1 | Completion flag A pulse |
| irq_b | output | 1 | Completion flag B pulse |
| err | output | 1 | Rejected-descriptor pulse |

## Verification
The abort input and the completion of the final element can land on the same clock edge. The bench provokes this by raising abort exactly in the cycle it acknowledges the last write of a chained descriptor. It then expects the flag pulses to appear while the engine falls to rest instead of waiting for another descriptor. A second collision, an abort arriving while a read is outstanding, is judged by requiring that the matching write still completes before the engine halts.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

    localparam int CNT_W  = 10;
    localparam int STEP_W = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_READ,
        ST_WRITE,
        ST_LINK
    } eng_state_t;

    // Packed MSB first: cfg_ok lands on bit 0.
    typedef struct packed {
        logic [CNT_W-1:0] count_m1;
        logic [1:0]       dst_step;
        logic [1:0]       src_step;
        logic [1:0]       width;
        logic             flag_b;
        logic             flag_a;
        logic             sw_go;
        logic             chain;
        logic             cfg_ok;
    } xfer_desc_t;

    localparam int DESC_W = $bits(xfer_desc_t);

    // Byte distance for one address step.
    function automatic logic [STEP_W-1:0] step_bytes(input logic [1:0] width,
                                                     input logic [1:0] mode);
        logic [STEP_W-1:0] unit;
        unit = STEP_W'(1) << width;
        case (mode)
            2'd0:    return '0;
            2'd1:    return unit;
            2'd2:    return unit << 1;
            default: return unit << 2;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_walk.sv
module dma_addr_walk import dma_eng_pkg::*; #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              adv,
    input  logic [STEP_W-1:0] stride,
    output logic [ADDR_W-1:0] addr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= base;
        else if (adv)
            addr <= addr + ADDR_W'(stride);
    end

endmodule

// File: rtl/dma_elem_count.sv
module dma_elem_count #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] init,
    input  logic             dec,
    output logic             last
);

    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            left_q <= '0;
        else if (load)
            left_q <= init;
        else if (dec)
            left_q <= left_q - 1'b1;
    end

    assign last = (left_q == '0);

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine import dma_eng_pkg::*; #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_load,
    input  logic [DESC_W-1:0] desc_word,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic              hw_req,
    input  logic              abort,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              irq_a,
    output logic              irq_b,
    output logic              err
);

    localparam logic [1:0] WIDTH_BAD = 2'd3;

    eng_state_t state, nxt;
    xfer_desc_t desc;

    logic              loadable, accept, reject;
    logic              wr_done, last, stop_q, stop_now;
    logic [1:0]        width_q, sstep_q, dstep_q;
    logic              fa_q, fb_q, chain_q;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic [DATA_W-1:0] rbuf_q;

    assign desc     = xfer_desc_t'(desc_word);
    assign loadable = (state == ST_IDLE) || (state == ST_ARMED) || (state == ST_LINK);
    assign accept   = loadable && desc_load && desc.cfg_ok && (desc.width != WIDTH_BAD);
    assign reject   = loadable && desc_load && desc.cfg_ok && (desc.width == WIDTH_BAD);
    assign wr_done  = (state == ST_WRITE) && mem_ack;
    assign stop_now = stop_q || abort;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_ARMED, ST_LINK: begin
                if (accept)
                    nxt = (desc.sw_go || state == ST_LINK) ? ST_READ : ST_ARMED;
                else if (reject)
                    nxt = ST_IDLE;
                else if (abort)
                    nxt = ST_IDLE;
                else if (state == ST_ARMED && hw_req)
                    nxt = ST_READ;
            end
            ST_READ: begin
                if (mem_ack)
                    nxt = ST_WRITE;
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    if (last)
                        nxt = (chain_q && !stop_now) ? ST_LINK : ST_IDLE;
                    else
                        nxt = stop_now ? ST_IDLE : ST_READ;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req   = (state == ST_READ) || (state == ST_WRITE);
        mem_we    = (state == ST_WRITE);
        mem_addr  = (state == ST_WRITE) ? dst_addr : src_addr;
        mem_size  = width_q;
        mem_wdata = rbuf_q;
        busy      = mem_req || (state == ST_LINK);
    end

    // Descriptor fields, data buffer, abort latch, pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q <= '0;
            sstep_q <= '0;
            dstep_q <= '0;
            fa_q    <= 1'b0;
            fb_q    <= 1'b0;
            chain_q <= 1'b0;
            rbuf_q  <= '0;
            stop_q  <= 1'b0;
            irq_a   <= 1'b0;
            irq_b   <= 1'b0;
            err     <= 1'b0;
        end else begin
            if (accept) begin
                width_q <= desc.width;
                sstep_q <= desc.src_step;
                dstep_q <= desc.dst_step;
                fa_q    <= desc.flag_a;
                fb_q    <= desc.flag_b;
                chain_q <= desc.chain;
            end
            if (state == ST_READ && mem_ack)
                rbuf_q <= mem_rdata;
            stop_q <= mem_req && stop_now && !wr_done;
            irq_a  <= wr_done && last && fa_q;
            irq_b  <= wr_done && last && fb_q;
            err    <= reject;
        end
    end

    dma_addr_walk #(.ADDR_W(ADDR_W)) u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .base   (src_base),
        .adv    (wr_done),
        .stride (step_bytes(width_q, sstep_q)),
        .addr   (src_addr)
    );

    dma_addr_walk #(.ADDR_W(ADDR_W)) u_dst (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .base   (dst_base),
        .adv    (wr_done),
        .stride (step_bytes(width_q, dstep_q)),
        .addr   (dst_addr)
    );

    dma_elem_count #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .init  (desc.count_m1),
        .dec   (wr_done && !last),
        .last  (last)
    );

endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        mem_size,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              busy,
    input logic              irq_a,
    input logic              irq_b,
    input logic              err
);

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R4

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && !mem_we |=> mem_req && mem_we); // R4

    AST_WDATA_IS_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && !mem_we |=> mem_wdata == $past(mem_rdata)); // R4

    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_size != 2'd3); // R2

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !mem_req && !busy); // R2

    AST_FLAG_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_a || irq_b) |-> !mem_req); // R7

    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R8

endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_dma_xfer_engine.sv
`timescale 1ns/1ps
module sim_dma_xfer_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_load = 1'b0;
    logic [20:0] desc_word = '0;
    logic [31:0] src_base = '0, dst_base = '0;
    logic        hw_req = 1'b0, abort = 1'b0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic [1:0]  mem_size;
    logic        busy, irq_a, irq_b, err;

    always #10 clk = ~clk;

    dma_xfer_engine u0 (
        .clk(clk), .rst_n(rst_n), .desc_load(desc_load), .desc_word(desc_word),
        .src_base(src_base), .dst_base(dst_base), .hw_req(hw_req), .abort(abort),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .irq_a(irq_a), .irq_b(irq_b), .err(err)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Reference model state (phase: 0 rest, 1 wait trigger, 2 read, 3 write, 4 wait chain)
    int          m_ph = 0, m_left = 0, m_sstep = 0, m_dstep = 0, m_w = 0;
    logic [31:0] m_src = 0, m_dst = 0, m_rdaddr = 0;
    bit          m_fa, m_fb, m_chain, m_stop, m_busy, m_ia, m_ib, m_err;
    int          lat_cnt = 0, lat_target = 0;
    int          n_wr = 0, n_irq = 0;
    bit          abort_on_last = 0;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[15:0]};
    endfunction

    function automatic logic [20:0] mk(input bit v, ch, sw, fa, fb, input int w, ss, ds, cnt);
        return {10'(cnt), 2'(ds), 2'(ss), 2'(w), fb, fa, sw, ch, v};
    endfunction

    function automatic int stride(input int w, input int code);
        return (code == 0) ? 0 : ((1 << w) << (code - 1));
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input bit ld, input logic [20:0] dw, input logic [31:0] sb, input logic [31:0] db,
                        input bit hw, input bit ab_in);
        bit ack, ab, in_xfer, stopnow;
        @(negedge clk);
        in_xfer = (m_ph == 2 || m_ph == 3);
        chk(busy === m_busy, "R8 busy", 32'(busy), 32'(m_busy));
        chk(irq_a === m_ia, "R7 irq_a", 32'(irq_a), 32'(m_ia));
        chk(irq_b === m_ib, "R7 irq_b", 32'(irq_b), 32'(m_ib));
        chk(err === m_err, "R2 err", 32'(err), 32'(m_err));
        chk(mem_req === in_xfer, "R4 mem_req", 32'(mem_req), 32'(in_xfer));
        if (in_xfer && mem_req) begin
            chk(mem_we === (m_ph == 3), "R4 direction", 32'(mem_we), 32'(m_ph == 3));
            chk(mem_addr === ((m_ph == 3) ? m_dst : m_src), "R5 address", mem_addr, (m_ph == 3) ? m_dst : m_src);
            chk(mem_size === 2'(m_w), "R4 size", 32'(mem_size), 32'(m_w));
            if (m_ph == 3) chk(mem_wdata === pat(m_rdaddr), "R4 write data", mem_wdata, pat(m_rdaddr));
        end
        if (irq_a || irq_b) n_irq++;
        ack = in_xfer && (lat_cnt >= lat_target);
        ab = ab_in;
        if (abort_on_last && m_ph == 3 && ack && m_left == 0) ab = 1;
        if (mem_req && mem_we && ack) n_wr++;
        desc_load = ld; desc_word = dw; src_base = sb; dst_base = db;
        hw_req = hw; abort = ab; mem_ack = ack; mem_rdata = pat(m_src);
        lat_cnt = (ack || !in_xfer) ? 0 : lat_cnt + 1;
        // model advance
        m_ia = 0; m_ib = 0; m_err = 0;
        if (m_ph == 0 || m_ph == 1 || m_ph == 4) begin
            if (ld && dw[0] && dw[6:5] == 2'd3) begin
                m_err = 1; m_ph = 0;
            end else if (ld && dw[0]) begin
                m_chain = dw[1]; m_fa = dw[3]; m_fb = dw[4]; m_w = int'(dw[6:5]);
                m_sstep = int'(dw[8:7]); m_dstep = int'(dw[10:9]); m_left = int'(dw[20:11]);
                m_src = sb; m_dst = db; m_stop = 0;
                m_ph = (dw[2] || m_ph == 4) ? 2 : 1;
            end else if (ab) m_ph = 0;
            else if (hw && m_ph == 1) m_ph = 2;
        end else if (m_ph == 2) begin
            if (ab) m_stop = 1;
            if (ack) begin m_rdaddr = m_src; m_ph = 3; end
        end else begin
            stopnow = m_stop || ab;
            if (ack) begin
                m_src = m_src + 32'(stride(m_w, m_sstep));
                m_dst = m_dst + 32'(stride(m_w, m_dstep));
                m_stop = 0;
                if (m_left == 0) begin
                    m_ia = m_fa; m_ib = m_fb;
                    m_ph = (m_chain && !stopnow) ? 4 : 0;
                end else if (stopnow) m_ph = 0;
                else begin m_left--; m_ph = 2; end
            end else if (ab) m_stop = 1;
        end
        m_busy = (m_ph == 2 || m_ph == 3 || m_ph == 4);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, '0, '0, 0, 0);
    endtask

    task automatic run_to(input int ph);
        for (int i = 0; i < 5000 && m_ph != ph; i++) idle(1);
        idle(2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy === 1'b0, "R8 reset busy", 32'(busy), 0);
        chk(mem_req === 1'b0, "R4 reset mem_req", 32'(mem_req), 0);
        rst_n = 1'b1;
        idle(2);

        // R3 R5 R6 R7: software start, 32-bit, step one width each side, four elements
        lat_target = 0; n_wr = 0; n_irq = 0;
        step(1, mk(1,0,1,1,0, 2,1,1, 3), 32'h1000, 32'h2000, 0, 0);
        run_to(0);
        chk(n_wr == 4, "R6 four elements", 32'(n_wr), 4);
        chk(n_irq == 1, "R7 one flag pulse", 32'(n_irq), 1);

        // R3: hardware trigger, 8-bit, fixed source, dest step 4x, single element
        lat_target = 2; n_wr = 0;
        step(1, mk(1,0,0,0,1, 0,0,3, 0), 32'h3001, 32'h4000, 0, 0);
        idle(3);
        chk(busy === 1'b0, "R3 not busy while waiting trigger", 32'(busy), 0);
        step(0, '0, '0, '0, 1, 0);
        run_to(0);
        chk(n_wr == 1, "R6 single element", 32'(n_wr), 1);

        // R9: chained descriptor continues without a trigger
        lat_target = 1; n_wr = 0;
        step(1, mk(1,1,1,1,0, 1,2,0, 2), 32'h5000, 32'h6000, 0, 0);
        run_to(4);
        idle(3);
        chk(busy === 1'b1, "R9 busy while waiting chain", 32'(busy), 1);
        step(1, mk(1,0,0,0,1, 2,3,1, 1), 32'h7000, 32'h8000, 0, 0);
        run_to(0);
        chk(n_wr == 5, "R9 both descriptors moved", 32'(n_wr), 5);

        // R2: reserved width rejected
        n_wr = 0;
        step(1, mk(1,0,1,1,1, 3,1,1, 5), 32'h9000, 32'hA000, 0, 0);
        idle(4);
        chk(n_wr == 0, "R2 no data moved", 32'(n_wr), 0);

        // R1: load with valid bit clear is ignored, trigger then has no effect
        step(1, mk(0,0,1,1,0, 2,1,1, 3), 32'hB000, 32'hC000, 0, 0);
        idle(2);
        step(0, '0, '0, '0, 1, 0);
        idle(3);
        chk(n_wr == 0 && busy === 1'b0, "R1 invalid descriptor ignored", 32'(n_wr), 0);

        // R10: abort mid transfer, then abort while waiting for trigger
        lat_target = 3; n_wr = 0; n_irq = 0;
        step(1, mk(1,0,1,1,1, 2,1,1, 9), 32'h0100, 32'h0800, 0, 0);
        idle(10);
        step(0, '0, '0, '0, 0, 1);
        run_to(0);
        chk(n_wr >= 1 && n_wr < 10, "R10 stopped early", 32'(n_wr), 32'd2);
        chk(n_irq == 0, "R10 no flags after abort", 32'(n_irq), 0);
        n_wr = 0;
        step(1, mk(1,0,0,1,0, 0,1,1, 0), 32'h0200, 32'h0900, 0, 0);
        step(0, '0, '0, '0, 0, 1);
        step(0, '0, '0, '0, 1, 0);
        idle(4);
        chk(n_wr == 0, "R10 abort while armed", 32'(n_wr), 0);

        // R11: abort together with final write ack on a chained descriptor
        lat_target = 1; n_irq = 0; abort_on_last = 1;
        step(1, mk(1,1,1,1,1, 0,1,1, 2), 32'h0300, 32'h0A00, 0, 0);
        run_to(0);
        abort_on_last = 0;
        chk(n_irq == 1, "R11 flags still raised", 32'(n_irq), 1);
        chk(busy === 1'b0, "R11 chain not followed", 32'(busy), 0);

        // R6: maximum count, 1024 elements
        lat_target = 0; n_wr = 0;
        step(1, mk(1,0,1,0,1, 1,1,0, 1023), 32'h1_0000, 32'h2_0000, 0, 0);
        run_to(0);
        chk(n_wr == 1024, "R6 maximum count", 32'(n_wr), 1024);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule